// File: doc/BRIEF.md
# Transmit FIFO interrupt cause logic

This block tracks the fill level of a serial controller's transmit FIFO and gathers the transmit-side interrupt causes into one 32-bit cause word. The word has two kinds of bits. Some are level bits that follow the FIFO fill at all times. The others are sticky event bits that latch a one-cycle strobe and hold it until software clears it by writing a one. A mask register with the same bit layout selects which causes drive the single interrupt line.

The block does not contain the framing engine, the smart-card NACK detector or the shared-memory port. Those blocks send in their strobes and line levels. The FIFO capacity is derived from a memory of `MEM_DEPTH` words. It is halved, quartered or cut to one eighth of that memory, depending on the element-width setting.

Top module: `tx_irq_cause`

## Requirements
- R1: After reset, `fill` is 0, every event bit (5 to 10) is 0, the mask is 0 and `irq` is 0.
- R2: Bit 0 is 1 in FIFO mode whenever `fill` is strictly below `trig_level`.
- R3: The capacity is MEM_DEPTH/2 for `width_mode` 0, MEM_DEPTH/4 for 1, and MEM_DEPTH/8 for 2 or 3. Bit 1 is 1 in FIFO mode while `fill` is below the capacity. A push is accepted only in that state.
- R4: Bit 4 is 1 in FIFO mode exactly when `fill` is 0.
- R5: A `push` in FIFO mode while `fill` is at or above the capacity is discarded, and bit 5 is set on the next cycle.
- R6: A `take` in FIFO mode while `fill` is 0 removes nothing, and bit 6 is set on the next cycle.
- R7: Bit 9 is set when `stop_done` pulses while `shifter_idle` is 1 and, in FIFO mode, `fill` is 0.
- R8: Bit 10 is set when `shared_line` and `mid_strobe` are both 1 and `tx_level` differs from `rx_level`.
- R9: `blocked_evt` sets bit 7 and `nack_evt` sets bit 8.
- R10: With `fifo_mode` 0, bits 0, 1, 4, 5 and 6 read 0, and `push` and `take` leave `fill` unchanged.
- R11: A write with `clr_we` clears each event bit that has a one in `clr_data`. Level bits (0, 1, 4) whose condition still holds stay 1.
- R12: If an event and a clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R13: `mask_we` loads `mask_data` into the mask. `irq` is the OR of `cause & mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects FIFO mode |
| width_mode | input | 2 | Element width setting, sets the capacity |
| trig_level | input | FILL_W | Trigger threshold for bit 0 |
| push | input | 1 | Write attempt into the FIFO |
| take | input | 1 | Transmitter ready to take an entry |
| shifter_idle | input | 1 | Transmit shift register empty |
| stop_done | input | 1 | Final stop field finished |
| shared_line | input | 1 | TX and RX share one line |
| mid_strobe | input | 1 | Mid-bit sample strobe |
| tx_level | input | 1 | Level driven on TX |
| rx_level | input | 1 | Level sampled on RX |
| blocked_evt | input | 1 | Memory access blocked event |
| nack_evt | input | 1 | NACK received event |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 32 | Bits to clear |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 32 | New mask value |
| cause | output | 32 | Interrupt cause word |
| irq | output | 1 | Masked interrupt request |
| fill | output | FILL_W | FIFO entry count |

## Verification
Two functions can act on the same bit in one cycle: an event that sets a cause bit and a software write-one-to-clear of that bit. The bench drives `nack_evt` together with a clear of bit 8 and expects bit 8 to read 1. It also clears the empty bit and the overflow bit with a single write and expects the empty bit to stay 1 while the overflow bit goes to 0. Random stimulus produces many more such collisions, and these also include a push and a take that land in the same cycle. A bench model written from the requirements checks every cause group, `irq` and `fill` after each clock edge.

// File: rtl/tx_irq_cause.sv
module tx_irq_cause #(
  parameter int MEM_DEPTH = 16,
  parameter int FILL_W    = $clog2(MEM_DEPTH/2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic [1:0]        width_mode,
  input  logic [FILL_W-1:0] trig_level,
  input  logic              push,
  input  logic              take,
  input  logic              shifter_idle,
  input  logic              stop_done,
  input  logic              shared_line,
  input  logic              mid_strobe,
  input  logic              tx_level,
  input  logic              rx_level,
  input  logic              blocked_evt,
  input  logic              nack_evt,
  input  logic              clr_we,
  input  logic [31:0]       clr_data,
  input  logic              mask_we,
  input  logic [31:0]       mask_data,
  output logic [31:0]       cause,
  output logic              irq,
  output logic [FILL_W-1:0] fill
);
  localparam int          HALF     = MEM_DEPTH / 2;
  localparam logic [31:0] EV_BITS  = 32'h0000_07E0;
  localparam logic [31:0] NOFIFO_V = 32'h0000_0780;

  logic [FILL_W-1:0] fill_q, cap;
  logic [31:0]       ev_q, ev_set, clr, mask_q, lvl;
  logic [1:0]        shift;
  logic              full, empty, push_ok, take_ok;

  assign shift   = (width_mode == 2'd3) ? 2'd2 : width_mode;
  assign cap     = FILL_W'(HALF) >> shift;
  assign full    = fill_q >= cap;
  assign empty   = fill_q == '0;
  assign push_ok = fifo_mode & push & ~full;
  assign take_ok = fifo_mode & take & ~empty;
  assign clr     = clr_we ? clr_data : 32'd0;

  always_comb begin
    ev_set     = '0;
    ev_set[5]  = fifo_mode & push & full;
    ev_set[6]  = fifo_mode & take & empty;
    ev_set[7]  = blocked_evt;
    ev_set[8]  = nack_evt;
    ev_set[9]  = stop_done & shifter_idle & (~fifo_mode | empty);
    ev_set[10] = shared_line & mid_strobe & (tx_level ^ rx_level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      fill_q <= fill_q + FILL_W'(push_ok) - FILL_W'(take_ok);
      ev_q   <= ((ev_q & ~clr) | ev_set) & EV_BITS;
      if (mask_we) mask_q <= mask_data;
    end
  end

  always_comb begin
    lvl    = '0;
    lvl[0] = fifo_mode & (fill_q < trig_level);
    lvl[1] = fifo_mode & ~full;
    lvl[4] = fifo_mode & empty;
  end

  assign cause = lvl | (ev_q & (fifo_mode ? EV_BITS : NOFIFO_V));
  assign irq   = |(cause & mask_q);
  assign fill  = fill_q;

  p_fill_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(HALF));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && push && full && !take) |=> (fill_q == $past(fill_q) && ev_q[5]));
  p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && take && empty) |=> ev_q[6]);
  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && shifter_idle && !fifo_mode) |=> ev_q[9]);
  p_arb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_line && mid_strobe && tx_level != rx_level) |=> ev_q[10]);
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> fill_q == $past(fill_q));
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_evt && clr_we && clr_data[8]) |=> cause[8]);
endmodule

// File: tb/sim_tx_irq_cause.sv
`timescale 1ns/1ps
module sim_tx_irq_cause;
  localparam int MEM_DEPTH = 16;
  localparam int FW = $clog2(MEM_DEPTH/2 + 1);

  logic clk = 0, rst_n = 0;
  logic fifo_mode, push, take, shifter_idle, stop_done, shared_line, mid_strobe;
  logic tx_level, rx_level, blocked_evt, nack_evt, clr_we, mask_we;
  logic [1:0] width_mode;
  logic [FW-1:0] trig_level, fill;
  logic [31:0] clr_data, mask_data, cause;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_cnt;
  logic [31:0] m_ev, m_mask;

  always #2.5 clk = ~clk;

  tx_irq_cause #(.MEM_DEPTH(MEM_DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .width_mode(width_mode),
    .trig_level(trig_level), .push(push), .take(take), .shifter_idle(shifter_idle),
    .stop_done(stop_done), .shared_line(shared_line), .mid_strobe(mid_strobe),
    .tx_level(tx_level), .rx_level(rx_level), .blocked_evt(blocked_evt),
    .nack_evt(nack_evt), .clr_we(clr_we), .clr_data(clr_data), .mask_we(mask_we),
    .mask_data(mask_data), .cause(cause), .irq(irq), .fill(fill));

  function automatic int capf(input logic [1:0] wm);
    return (MEM_DEPTH/2) >> ((wm == 2'd3) ? 2 : wm);
  endfunction

  function automatic logic [31:0] exp_cause();
    logic [31:0] c = '0;
    c[0] = fifo_mode && (m_cnt < int'(trig_level));
    c[1] = fifo_mode && (m_cnt < capf(width_mode));
    c[4] = fifo_mode && (m_cnt == 0);
    c = c | (m_ev & (fifo_mode ? 32'h7E0 : 32'h780));
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] s = '0;
    int cap = capf(width_mode);
    bit full = m_cnt >= cap, empty = m_cnt == 0;
    s[5] = fifo_mode && push && full;
    s[6] = fifo_mode && take && empty;
    s[7] = blocked_evt;
    s[8] = nack_evt;
    s[9] = stop_done && shifter_idle && (!fifo_mode || empty);
    s[10] = shared_line && mid_strobe && (tx_level != rx_level);
    m_ev = ((m_ev & ~(clr_we ? clr_data : 32'd0)) | s) & 32'h7E0;
    if (mask_we) m_mask = mask_data;
    if (fifo_mode && push && !full) m_cnt++;
    if (fifo_mode && take && !empty) m_cnt--;
  endtask

  task automatic compare_all();
    logic [31:0] e = exp_cause();
    check("R2 trigger", 32'(cause[0]), 32'(e[0]));
    check("R3 not_full", 32'(cause[1]), 32'(e[1]));
    check("R4 empty", 32'(cause[4]), 32'(e[4]));
    check("R5 overflow", 32'(cause[5]), 32'(e[5]));
    check("R6 underflow", 32'(cause[6]), 32'(e[6]));
    check("R9 blocked/nack", 32'(cause[8:7]), 32'(e[8:7]));
    check("R7 done", 32'(cause[9]), 32'(e[9]));
    check("R8 arb", 32'(cause[10]), 32'(e[10]));
    check("R11 unused bits", cause & ~32'h7F3, 32'd0);
    check("R13 irq", 32'(irq), 32'(|(e & m_mask)));
    check("R10 fill", 32'(fill), 32'(m_cnt));
  endtask

  task automatic idle();
    push = 0; take = 0; stop_done = 0; mid_strobe = 0; blocked_evt = 0;
    nack_evt = 0; clr_we = 0; clr_data = 0; mask_we = 0; mask_data = 0;
    shared_line = 0; tx_level = 1; rx_level = 1; shifter_idle = 1;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    fifo_mode = 1; width_mode = 0; trig_level = FW'(2);
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_cnt = 0; m_ev = 0; m_mask = 0;
    // R1 reset state
    check("R1 fill", 32'(fill), 0);
    check("R1 cause", cause, 32'h13);
    check("R1 irq", 32'(irq), 0);
    mask_we = 1; mask_data = 32'hFFFF_FFFF; tick(); idle();
    // R3 R5: fill to capacity, then overflow
    for (int i = 0; i < 9; i++) begin push = 1; tick(); end
    idle();
    check("R5 fill held at capacity", 32'(fill), 8);
    check("R5 overflow set", 32'(cause[5]), 1);
    check("R3 not_full low", 32'(cause[1]), 0);
    width_mode = 2'd3; tick();
    check("R3 capacity wm3", 32'(cause[1]), 0);
    width_mode = 0;
    // R6 drain then underflow
    for (int i = 0; i < 9; i++) begin take = 1; tick(); end
    idle();
    check("R6 underflow set", 32'(cause[6]), 1);
    // R11 clear empty and overflow together
    clr_we = 1; clr_data = 32'h30; tick(); idle();
    check("R11 empty stays", 32'(cause[4]), 1);
    check("R11 overflow cleared", 32'(cause[5]), 0);
    // R12 set wins over clear
    nack_evt = 1; clr_we = 1; clr_data = 32'h100; tick(); idle();
    check("R12 nack kept", 32'(cause[8]), 1);
    // R10 non-FIFO mode
    fifo_mode = 0; push = 1; tick(); idle();
    check("R10 fill frozen", 32'(fill), 0);
    check("R10 fifo bits zero", cause & 32'h73, 0);
    fifo_mode = 1;
    // R7 done, R8 arbitration
    stop_done = 1; tick(); idle();
    check("R7 done set", 32'(cause[9]), 1);
    shared_line = 1; mid_strobe = 1; tx_level = 1; rx_level = 0; tick(); idle();
    check("R8 arb set", 32'(cause[10]), 1);
    mask_we = 1; mask_data = 0; tick(); idle();
    check("R13 irq masked off", 32'(irq), 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 2) fifo_mode = ~fifo_mode;
      if ($urandom_range(0, 99) < 3) width_mode = 2'($urandom);
      if ($urandom_range(0, 99) < 3) trig_level = FW'($urandom_range(0, 8));
      push = ($urandom_range(0, 99) < 50);
      take = ($urandom_range(0, 99) < 40);
      shifter_idle = $urandom; stop_done = ($urandom_range(0, 9) == 0);
      shared_line = $urandom; mid_strobe = $urandom;
      tx_level = $urandom; rx_level = $urandom;
      blocked_evt = ($urandom_range(0, 19) == 0);
      nack_evt = ($urandom_range(0, 19) == 0);
      clr_we = ($urandom_range(0, 9) == 0); clr_data = $urandom;
      mask_we = ($urandom_range(0, 19) == 0); mask_data = $urandom;
      tick();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule